// File: doc/BRIEF.md
# Four-Lane Fixed-Topology MLP Inference Engine

This block runs one forward pass of a small fully connected network: 400 unsigned 8-bit inputs feed 8 hidden neurons, whose squashed outputs feed one output neuron. Four multiply-accumulate lanes share each input value. Every lane holds its own signed 8-bit weights. The hidden layer therefore takes two passes of four neurons, and each pass walks all 400 inputs.

Finished lane sums queue in a small sum FIFO. From there they drain one at a time through a single shared squashing stage into a result FIFO. Once all eight hidden results are queued, lane 0 combines them with the output weights and bias. The final sum goes through the same squashing stage and is presented as the 8-bit answer together with a one-cycle done pulse.

A host loads activations, hidden weights, hidden biases, output weights and the output bias through one write port while the block is idle, then pulses start.

Top module: `mlp_pe_array`

## Requirements
- R1: After reset, busy, done and y are all 0.
- R2: A write takes effect when wr_en is high at a clock edge, with the target chosen by wr_kind. Code 0 writes activation number wr_col. Code 1 writes the weight from input wr_col to hidden neuron wr_row. Code 2 writes the bias of hidden neuron wr_row. Code 3 writes the output weight of hidden neuron wr_col when wr_col is 0 to 7, and the output bias when wr_col is 8.
- R3: Hidden neuron h forms bias_h plus the sum over i of x_i times w_h,i. Activations are unsigned 8-bit, while weights and biases are signed 8-bit two's complement. The sum is held exactly in a 26-bit signed accumulator over all 400 terms.
- R4: The squashing function shifts a sum arithmetically right by 8 bits, giving s (floor division by 256). It returns 0 when s < -128, 255 when s > 127, and s + 128 otherwise.
- R5: The output neuron forms the output bias plus the sum over k of hk times ow_k, where hk is the squashed result of hidden neuron k (k = 0 to 7, paired by index). The final y is the squashed value of that sum.
- R6: busy is 1 from the cycle after start is accepted until done. done is a single-cycle pulse, busy is 0 while done is high, and y holds its value until the next done.
- R7: A start request while busy is ignored. The running evaluation finishes with exactly one done pulse and an unchanged result.
- R8: Each neuron's accumulator starts from its own bias, so running the same data twice gives the same y.
- R9: Full-scale positive data (all inputs 255, all weights and biases 127) gives y = 255. Negating the output weights to -128 gives y = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the load port |
| wr_kind | input | 2 | Write target class (see R2) |
| wr_row | input | 3 | Hidden neuron index for codes 1 and 2 |
| wr_col | input | 9 | Input index, or output-layer slot for code 3 |
| wr_data | input | 8 | Value written |
| start | input | 1 | Request one evaluation (sampled while idle) |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when y is updated |
| y | output | 8 | Final squashed output |

## Verification
The bench targets the squashing boundaries. A final sum of -1 must give 127 and a sum of 0 must give 128, so a design that truncates toward zero instead of flooring lands on the wrong side. It rewrites one hidden neuron's weight row and only the activation table, which exposes lane and pass mis-decoding as a wrong y. It pokes start in the first pass, in the second pass and in the output phase: a design that restarts would lose a pulse, emit two, or change y. It also repeats identical runs, since an accumulator that is not reloaded from its bias drifts from run to run.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  localparam int DW = 8;
  localparam int PW = 16;
  localparam int AW = 26;

  typedef logic [DW-1:0]        act_t;
  typedef logic signed [DW-1:0] wgt_t;
  typedef logic signed [PW-1:0] prod_t;
  typedef logic signed [AW-1:0] acc_t;

  typedef enum logic [1:0] {
    WK_ACT   = 2'd0,
    WK_HWGT  = 2'd1,
    WK_HBIAS = 2'd2,
    WK_OUT   = 2'd3
  } wkind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HMAC, S_HDRN, S_OWAIT, S_OMAC, S_ODRN, S_OFIN
  } fsm_e;

  localparam acc_t SQ_LO = acc_t'(-(2 ** (DW - 1)));
  localparam acc_t SQ_HI = acc_t'((2 ** (DW - 1)) - 1);

  // unsigned activation times signed weight, exact in PW bits
  function automatic prod_t mul_act(act_t x, wgt_t w);
    prod_t xe;
    prod_t we;
    xe = prod_t'({{(PW-DW){1'b0}}, x});
    we = prod_t'({{(PW-DW){w[DW-1]}}, w});
    return xe * we;
  endfunction

  function automatic acc_t widen_prod(prod_t p);
    return {{(AW-PW){p[PW-1]}}, p};
  endfunction

  function automatic acc_t widen_wgt(wgt_t b);
    return {{(AW-DW){b[DW-1]}}, b};
  endfunction

  // hard sigmoid: arithmetic shift, clamp, recentre to unsigned
  function automatic act_t squash(acc_t a, int unsigned sh);
    acc_t s;
    s = a >>> sh;
    if (s < SQ_LO) return '0;
    if (s > SQ_HI) return '1;
    return act_t'(s - SQ_LO);
  endfunction
endpackage

// File: rtl/mlp_fifo.sv
module mlp_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 4,
  localparam int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic [CNTW-1:0] count
);
  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] rp, wp;
  logic            full, empty;

  assign full  = (count == CNTW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PTRW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTRW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (push && full) |-> pop); // R5
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R5
endmodule

// File: rtl/mlp_sigmoid.sv
module mlp_sigmoid
  import mlp_pkg::*;
#(
  parameter int SHIFT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  acc_t in_acc,
  output logic out_valid,
  output act_t out_y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_y <= squash(in_acc, SHIFT);
    end
  end

  logic above_range, below_range;
  assign above_range = in_valid && ((in_acc >>> SHIFT) > SQ_HI);
  assign below_range = in_valid && ((in_acc >>> SHIFT) < SQ_LO);

  AST_SQUASH_CLAMP_HI: assert property (@(posedge clk) disable iff (!rst_n) above_range |=> (out_valid && out_y == '1)); // R4
  AST_SQUASH_CLAMP_LO: assert property (@(posedge clk) disable iff (!rst_n) below_range |=> (out_valid && out_y == '0)); // R4
endmodule

// File: rtl/mlp_pe.sv
module mlp_pe
  import mlp_pkg::*;
#(
  parameter  int DEPTH = 800,
  localparam int AWID  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AWID-1:0] wr_addr,
  input  wgt_t            wr_data,
  input  logic [AWID-1:0] rd_addr,
  input  logic            ovr_en,
  input  wgt_t            ovr_w,
  input  act_t            x,
  input  logic            clr,
  input  acc_t            clr_val,
  input  logic            mac,
  output acc_t            acc
);
  wgt_t  wmem [DEPTH];
  wgt_t  w_sel;
  prod_t prod;

  always_ff @(posedge clk) begin
    if (wr_en) wmem[wr_addr] <= wr_data;
  end

  assign w_sel = ovr_en ? ovr_w : wmem[rd_addr];
  assign prod  = mul_act(x, w_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= clr_val;
    else if (mac) acc <= acc + widen_prod(prod);
  end

  AST_CLR_MAC_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(clr && mac)); // R8
  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (mac && !clr && !acc[AW-1] && !prod[PW-1]) |=> !acc[AW-1]); // R3
endmodule

// File: rtl/mlp_pe_array.sv
module mlp_pe_array
  import mlp_pkg::*;
#(
  parameter  int N_IN   = 400,
  parameter  int N_HID  = 8,
  parameter  int N_PE   = 4,
  parameter  int SHIFT  = 8,
  localparam int N_PASS = N_HID / N_PE,
  localparam int PDEP   = N_PASS * N_IN,
  localparam int PAW    = $clog2(PDEP),
  localparam int IW     = $clog2(N_IN),
  localparam int KW     = $clog2(N_HID),
  localparam int CW     = $clog2(N_IN),
  localparam int PSW    = (N_PASS > 1) ? $clog2(N_PASS) : 1,
  localparam int DKW    = (N_PE > 1) ? $clog2(N_PE) : 1,
  localparam int ACW    = $clog2(N_PE + 1),
  localparam int SCW    = $clog2(N_HID + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [KW-1:0] wr_row,
  input  logic [CW-1:0] wr_col,
  input  logic [DW-1:0] wr_data,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] y
);
  // parameter storage outside the lanes
  act_t xmem [N_IN];
  wgt_t hb   [N_HID];
  wgt_t ow   [N_HID];
  wgt_t ob;

  fsm_e           st;
  logic [IW-1:0]  idx;
  logic [PSW-1:0] pass;
  logic [DKW-1:0] dk;
  logic [KW-1:0]  k;

  int row_i, col_i, nxt_pass;
  always_comb begin
    row_i    = int'(wr_row);
    col_i    = int'(wr_col);
    nxt_pass = (st == S_IDLE) ? 0 : int'(pass) + 1;
  end

  // load port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_kind)
        WK_ACT:   if (col_i < N_IN) xmem[wr_col] <= wr_data;
        WK_HBIAS: if (row_i < N_HID) hb[wr_row] <= wr_data;
        WK_OUT: begin
          if (col_i < N_HID)       ow[wr_col[KW-1:0]] <= wr_data;
          else if (col_i == N_HID) ob <= wr_data;
        end
        default: ;
      endcase
    end
  end

  // named control events
  logic hmac, omac, hid_last, pass_last, drn_last, out_clr, clr_all, fin_take, start_ignored;
  logic acc_push, acc_empty, sig_valid, sig_pop, sig_empty;
  logic [ACW-1:0] acc_cnt;
  logic [SCW-1:0] sig_cnt;
  acc_t acc_din, acc_dout;
  act_t sig_y, sig_rd, pe_x;
  acc_t pe_acc [N_PE];

  assign hmac          = (st == S_HMAC);
  assign omac          = (st == S_OMAC);
  assign hid_last      = hmac && (idx == IW'(N_IN - 1));
  assign pass_last     = (pass == PSW'(N_PASS - 1));
  assign drn_last      = (st == S_HDRN) && (dk == DKW'(N_PE - 1));
  assign out_clr       = (st == S_OWAIT) && (sig_cnt == SCW'(N_HID));
  assign clr_all       = ((st == S_IDLE) && start) || (drn_last && !pass_last);
  assign fin_take      = (st == S_OFIN) && !sig_empty;
  assign start_ignored = start && busy;
  assign busy          = (st != S_IDLE);

  assign pe_x     = omac ? sig_rd : xmem[idx];
  assign acc_push = (st == S_HDRN) || (st == S_ODRN);
  assign acc_din  = (st == S_ODRN) ? pe_acc[0] : pe_acc[dk];

  logic [PAW-1:0] pe_waddr, pe_raddr;
  assign pe_waddr = PAW'((row_i / N_PE) * N_IN + col_i);
  assign pe_raddr = PAW'(int'(pass) * N_IN + int'(idx));

  // lanes: lane p owns neurons p, p+N_PE, ...
  for (genvar p = 0; p < N_PE; p++) begin : g_lane
    logic lane_wen, lane_clr, lane_mac, lane_ovr;
    acc_t lane_clrv;
    assign lane_wen  = wr_en && (wr_kind == WK_HWGT) && (row_i % N_PE == p) && (col_i < N_IN);
    assign lane_clrv = (st == S_OWAIT) ? widen_wgt(ob) : widen_wgt(hb[(nxt_pass * N_PE + p) % N_HID]);
    if (p == 0) begin : g_head
      assign lane_clr = clr_all || out_clr;
      assign lane_mac = hmac || omac;
      assign lane_ovr = omac;
    end else begin : g_body
      assign lane_clr = clr_all;
      assign lane_mac = hmac;
      assign lane_ovr = 1'b0;
    end
    mlp_pe #(.DEPTH(PDEP)) u_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lane_wen),
      .wr_addr (pe_waddr),
      .wr_data (wr_data),
      .rd_addr (pe_raddr),
      .ovr_en  (lane_ovr),
      .ovr_w   (ow[k]),
      .x       (pe_x),
      .clr     (lane_clr),
      .clr_val (lane_clrv),
      .mac     (lane_mac),
      .acc     (pe_acc[p])
    );
  end

  mlp_fifo #(.W(AW), .DEPTH(N_PE)) u_sum_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (acc_push),
    .din   (acc_din),
    .pop   (!acc_empty),
    .dout  (acc_dout),
    .count (acc_cnt)
  );
  assign acc_empty = (acc_cnt == '0);

  mlp_sigmoid #(.SHIFT(SHIFT)) u_squash (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (!acc_empty),
    .in_acc    (acc_dout),
    .out_valid (sig_valid),
    .out_y     (sig_y)
  );

  mlp_fifo #(.W(DW), .DEPTH(N_HID)) u_res_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (sig_valid),
    .din   (sig_y),
    .pop   (sig_pop),
    .dout  (sig_rd),
    .count (sig_cnt)
  );
  assign sig_empty = (sig_cnt == '0);
  assign sig_pop   = omac || fin_take;

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      idx  <= '0;
      pass <= '0;
      dk   <= '0;
      k    <= '0;
      done <= 1'b0;
      y    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pass <= '0;
          idx  <= '0;
          st   <= S_HMAC;
        end
        S_HMAC: begin
          idx <= idx + 1'b1;
          if (hid_last) begin
            dk <= '0;
            st <= S_HDRN;
          end
        end
        S_HDRN: begin
          dk <= dk + 1'b1;
          if (drn_last) begin
            if (pass_last) st <= S_OWAIT;
            else begin
              pass <= pass + 1'b1;
              idx  <= '0;
              st   <= S_HMAC;
            end
          end
        end
        S_OWAIT: if (out_clr) begin
          k  <= '0;
          st <= S_OMAC;
        end
        S_OMAC: begin
          k <= k + 1'b1;
          if (k == KW'(N_HID - 1)) st <= S_ODRN;
        end
        S_ODRN: st <= S_OFIN;
        S_OFIN: if (fin_take) begin
          y    <= sig_rd;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (start_ignored && hmac && !hid_last) |=> (idx == IW'($past(idx) + IW'(1)))); // R7
  AST_OMAC_FED: assert property (@(posedge clk) disable iff (!rst_n) omac |-> !sig_empty); // R5
endmodule

// File: tb/test_mlp_pe_array.sv
module test_mlp_pe_array;
  localparam int NI = 400;
  localparam int NH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_kind = '0;
  logic [2:0] wr_row = '0;
  logic [8:0] wr_col = '0;
  logic [7:0] wr_data = '0;
  logic       start = 1'b0;
  logic       busy, done;
  logic [7:0] y;

  always #4 clk = ~clk;

  mlp_pe_array i_mlp_pe_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data), .start(start), .busy(busy), .done(done), .y(y)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int xm [NI];
  int hwm [NH][NI];
  int hbm [NH];
  int owm [NH];
  int obm;

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // floor(a/256), then clamp and recentre
  function automatic int ref_sq(int a);
    int s;
    if (a >= 0) s = a / 256;
    else        s = -((-a + 255) / 256);
    if (s < -128) return 0;
    if (s > 127)  return 255;
    return s + 128;
  endfunction

  function automatic int ref_net();
    int hv [NH];
    int a;
    for (int h = 0; h < NH; h++) begin
      a = hbm[h];
      for (int i = 0; i < NI; i++) a += xm[i] * hwm[h][i];
      hv[h] = ref_sq(a);
    end
    a = obm;
    for (int h = 0; h < NH; h++) a += hv[h] * owm[h];
    return ref_sq(a);
  endfunction

  task automatic wr(input int kind, input int row, input int col, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_row = 3'(row); wr_col = 9'(col); wr_data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_acts();
    for (int i = 0; i < NI; i++) wr(0, 0, i, xm[i]);
  endtask

  task automatic load_out();
    for (int h = 0; h < NH; h++) wr(3, 0, h, owm[h]);
    wr(3, 0, NH, obm);
  endtask

  task automatic load_all();
    load_acts();
    for (int h = 0; h < NH; h++) begin
      for (int i = 0; i < NI; i++) wr(1, h, i, hwm[h][i]);
      wr(2, h, 0, hbm[h]);
    end
    load_out();
  endtask

  // one evaluation; poke = cycle index at which start is raised again (-1 none)
  task automatic run_inf(input string tag, input int poke, output int yv, output int pulses);
    int cyc;
    cyc = 0; pulses = 0; yv = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " R6 busy after start"}, int'(busy), 1);
    while (pulses == 0 && cyc < 5000) begin
      start = (cyc == poke);
      @(negedge clk);
      cyc++;
      if (done) begin pulses++; yv = int'(y); end
    end
    start = 1'b0;
    if (pulses == 0) chk({tag, " R6 done timeout"}, 0, 1);
    @(negedge clk);
    chk({tag, " R6 done lasts one cycle"}, int'(done), 0);
    chk({tag, " R6 idle after done"}, int'(busy), 0);
    if (done) pulses++;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    chk({tag, " R6 y held"}, int'(y), yv);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 done at reset", int'(done), 0);
    chk("R1 y at reset", int'(y), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_mid();
    int yv, np;
    for (int i = 0; i < NI; i++) xm[i] = (i * 37 + 11) % 64;
    for (int h = 0; h < NH; h++) begin
      for (int i = 0; i < NI; i++) hwm[h][i] = ((i * 5 + h * 3) % 5) - 2;
      hbm[h] = (h * 29) % 50 - 25;
      owm[h] = (h % 2 == 1) ? -3 * (h + 1) : 4 * (h + 1);
    end
    obm = -40;
    load_all();
    run_inf("mid", -1, yv, np);
    chk("R3 R5 mid-range network", yv, ref_net());
    chk("R7 one pulse mid", np, 1);
  endtask

  task automatic t_spread_pokes();
    int yv, np, e;
    for (int i = 0; i < NI; i++) xm[i] = (i * 91 + 7) % 256;
    for (int h = 0; h < NH; h++) begin
      for (int i = 0; i < NI; i++) hwm[h][i] = ((i * 13 + h * 41) % 61) - 30 + (h - 4) * 4;
      hbm[h] = 60 - h * 17;
      owm[h] = (h * 17) % 40 - 20;
    end
    obm = 100;
    load_all();
    e = ref_net();
    run_inf("spread", -1, yv, np);
    chk("R4 R5 saturating mix", yv, e);
    run_inf("poke pass0", 100, yv, np);
    chk("R7 start in first pass result", yv, e);
    chk("R7 start in first pass pulses", np, 1);
    run_inf("poke pass1", 500, yv, np);
    chk("R7 start in second pass result", yv, e);
    chk("R7 start in second pass pulses", np, 1);
    run_inf("poke out", 812, yv, np);
    chk("R7 start in output phase result", yv, e);
    chk("R7 start in output phase pulses", np, 1);
  endtask

  task automatic t_repeat();
    int y1, y2, np;
    run_inf("rep1", -1, y1, np);
    run_inf("rep2", -1, y2, np);
    chk("R8 repeated run identical", y2, y1);
    chk("R8 repeated run matches model", y2, ref_net());
  endtask

  task automatic t_row_decode();
    int yv, np;
    for (int i = 0; i < NI; i++) begin
      hwm[5][i] = 60 - (i % 7) * 20;
      wr(1, 5, i, hwm[5][i]);
    end
    run_inf("row5", -1, yv, np);
    chk("R2 hidden row 5 rewrite", yv, ref_net());
  endtask

  task automatic t_act_rewrite();
    int yv, np;
    for (int i = 0; i < NI; i++) xm[i] = (i < 200) ? 250 - (i % 50) : (i * 3) % 20;
    load_acts();
    run_inf("acts", -1, yv, np);
    chk("R2 activation rewrite", yv, ref_net());
  endtask

  task automatic t_saturate();
    int yv, np;
    for (int i = 0; i < NI; i++) xm[i] = 255;
    for (int h = 0; h < NH; h++) begin
      for (int i = 0; i < NI; i++) hwm[h][i] = 127;
      hbm[h] = 127;
      owm[h] = 127;
    end
    obm = 127;
    load_all();
    run_inf("sat hi", -1, yv, np);
    chk("R9 full-scale positive", yv, 255);
    for (int h = 0; h < NH; h++) owm[h] = -128;
    load_out();
    run_inf("sat lo", -1, yv, np);
    chk("R9 full-scale negative", yv, 0);
  endtask

  task automatic t_out_bias();
    int yv, np;
    for (int h = 0; h < NH; h++) owm[h] = 0;
    obm = -1;
    load_out();
    run_inf("bias m1", -1, yv, np);
    chk("R4 floor of -1 gives 127", yv, 127);
    obm = 0;
    wr(3, 0, NH, obm);
    run_inf("bias 0", -1, yv, np);
    chk("R2 output bias slot 8, sum 0 gives 128", yv, 128);
    obm = 127;
    wr(3, 0, NH, obm);
    owm[3] = 2;
    wr(3, 0, 3, owm[3]);
    run_inf("bias ow3", -1, yv, np);
    chk("R5 single output weight path", yv, ref_net());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R6 watchdog: actual 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_mid();
    t_spread_pokes();
    t_repeat();
    t_row_decode();
    t_act_rewrite();
    t_saturate();
    t_out_bias();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule